// File: doc/BRIEF.md
# Valid/Ready Channel Protocol Monitor

This block watches a single valid/ready channel of an AXI-style interface, for example the write-address channel. It never drives the bus. On every clock it judges the channel against four rules. The payload must carry no undefined bits while valid is high. The payload must not move while a transfer is stalled. Valid must not be dropped before the transfer is accepted. Valid must stay low while the bus is held in reset. Each rule owns a sticky flag. A one-cycle error pulse and a saturating count of offending cycles summarise all four rules.

The monitor has its own synchronous active-high reset and a synchronous sticky-clear input. The monitored bus reset, which is active low, is an ordinary observed input. The monitor stores the stall-checked part of the payload whenever valid is high and ready is low, and sets a stall-pending bit. On the next cycle it compares the live channel against that stored copy. All results are registered, so a rule broken in cycle t shows on the outputs just after the clock edge that closes cycle t.

Top module: `axi_hsk_monitor`

## Requirements
- R1: While valid is high, any X or Z bit in the whole payload {addr, id, len, size, burst} sets flag bit 0 (unknown payload). Under two-state evaluation, and in hardware, this flag never sets.
- R2: If the bus is out of reset with valid high and ready low in one cycle, then a change of {addr, len, size, burst} in the next cycle sets flag bit 1 (payload moved). A change of id alone sets nothing.
- R3: If the bus is out of reset with valid high and ready low in one cycle, then valid low in the next cycle sets flag bit 2 (valid withdrawn).
- R4: A cycle with valid and ready both high completes the transfer. In the next cycle the payload may change and valid may fall without any flag.
- R5: Valid high in a cycle where bus_rst_n is low sets flag bit 3 (valid during reset).
- R6: Bus reset clears the stall-pending state, and the bit 1 and bit 2 rules are not evaluated while bus_rst_n is low. The first cycle after the bus reset is released therefore never raises bit 1 or bit 2.
- R7: Each flag stays set until clr is high at a clock edge. If a rule fires in the same cycle that clr is high, its flag ends up set.
- R8: err_pulse is high for exactly the cycle after each cycle in which at least one rule fires.
- R9: viol_cnt increments by one for each cycle in which any rule fires, even when several rules fire together. It stops at all-ones, and clr leaves it unchanged.
- R10: rst clears all flags, err_pulse, viol_cnt and the stall-pending state.
- R11: The outputs are registered. A violation in cycle t is not visible before the clock edge that ends cycle t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Monitor synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the sticky flags |
| bus_rst_n | input | 1 | Observed bus reset, active low |
| valid | input | 1 | Observed channel valid |
| ready | input | 1 | Observed channel ready |
| addr | input | ADDR_W | Observed address |
| id | input | ID_W | Observed transaction ID |
| len | input | LEN_W | Observed burst length |
| size | input | 3 | Observed beat size |
| burst | input | 2 | Observed burst type |
| viol_flags | output | 4 | Sticky flags: bit0 unknown, bit1 moved, bit2 withdrawn, bit3 valid in reset |
| err_pulse | output | 1 | One-cycle pulse per offending cycle |
| viol_cnt | output | CNT_W | Saturating count of offending cycles |

## Verification
Two situations are hard to reach from the ports. The first is counter saturation: it needs tens of thousands of offending cycles. The bench holds the bus in reset with valid high, so every cycle breaks the reset rule, and runs until the count pins at all-ones. The second is a bus reset that arrives while a stall is pending. The bench creates a stall, asserts bus_rst_n low on the next cycle with a different payload and valid low, and then releases the reset with yet another payload. This confirms that the pending state is dropped and that no moved or withdrawn flag appears. The unknown-payload expectation is computed in the bench from its own driven vector. It therefore holds under both two-state and four-state evaluation.

// File: rtl/axi_hsk_pkg.sv
package axi_hsk_pkg;
  localparam int NUM_RULES = 4;
  localparam int SIZE_W    = 3;
  localparam int BURST_W   = 2;

  typedef enum int {
    RULE_UNKNOWN = 0,
    RULE_MOVED   = 1,
    RULE_DROPPED = 2,
    RULE_IN_RST  = 3
  } rule_e;

  typedef logic [NUM_RULES-1:0] rule_vec_t;
endpackage

// File: rtl/hsk_stall_tracker.sv
module hsk_stall_tracker #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_rst_n,
  input  logic         valid,
  input  logic         ready,
  input  logic [W-1:0] stab_vec,
  output logic         pend,
  output logic [W-1:0] saved
);
  logic stall_now;
  assign stall_now = valid && !ready;

  // pending bit: one stalled cycle is awaiting its follow-up comparison
  always_ff @(posedge clk) begin
    if (rst || !bus_rst_n) pend <= 1'b0;
    else                   pend <= stall_now;
  end

  // snapshot of the stall-checked payload
  always_ff @(posedge clk) begin
    if (stall_now) saved <= stab_vec;
  end

  // R6: pending only ever follows a stalled cycle outside bus reset
  p_pend_src_r6: assert property (@(posedge clk) disable iff (rst)
    pend |-> $past(bus_rst_n && valid && !ready));
  // R6: bus reset drops the pending state
  p_pend_clr_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_rst_n |=> !pend);
endmodule

// File: rtl/hsk_rule_eval.sv
module hsk_rule_eval
  import axi_hsk_pkg::*;
#(
  parameter int FULL_W = 16,
  parameter int STAB_W = 16
) (
  input  logic              bus_rst_n,
  input  logic              valid,
  input  logic              pend,
  input  logic [FULL_W-1:0] full_vec,
  input  logic [STAB_W-1:0] stab_vec,
  input  logic [STAB_W-1:0] saved,
  output rule_vec_t         fire
);
  logic has_unknown;

  // evaluates to zero in two-state logic and in silicon
  always_comb has_unknown = $isunknown(full_vec);

  always_comb begin
    fire               = '0;
    fire[RULE_UNKNOWN] = valid && has_unknown;
    fire[RULE_MOVED]   = bus_rst_n && pend && (stab_vec != saved);
    fire[RULE_DROPPED] = bus_rst_n && pend && !valid;
    fire[RULE_IN_RST]  = !bus_rst_n && valid;
  end
endmodule

// File: rtl/hsk_sticky_bank.sv
module hsk_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] fire,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flags[i] <= 1'b0;
      else if (fire[i]) flags[i] <= 1'b1;
      else if (clr)     flags[i] <= 1'b0;
    end

    // R7: a set flag survives any edge without clear
    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr) |=> flags[i]);
    // R7: a firing rule wins over a simultaneous clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      fire[i] |=> flags[i]);
  end
endmodule

// File: rtl/hsk_sat_counter.sv
module hsk_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
  end

  // R9: saturated value is held
  p_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXV) |=> (cnt == MAXV));
  // R9: no movement without an offending cycle
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/axi_hsk_monitor.sv
module axi_hsk_monitor
  import axi_hsk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 bus_rst_n,
  input  logic                 valid,
  input  logic                 ready,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ID_W-1:0]      id,
  input  logic [LEN_W-1:0]     len,
  input  logic [2:0]           size,
  input  logic [1:0]           burst,
  output logic [NUM_RULES-1:0] viol_flags,
  output logic                 err_pulse,
  output logic [CNT_W-1:0]     viol_cnt
);
  localparam int STAB_W = ADDR_W + LEN_W + SIZE_W + BURST_W;
  localparam int FULL_W = STAB_W + ID_W;

  logic [STAB_W-1:0] stab_vec, saved;
  logic [FULL_W-1:0] full_vec;
  logic              pend;
  logic              any_fire;
  rule_vec_t         fire;

  assign stab_vec = {addr, len, size, burst};
  assign full_vec = {addr, id, len, size, burst};
  assign any_fire = |fire;

  hsk_stall_tracker #(.W(STAB_W)) u_track (
    .clk(clk), .rst(rst), .bus_rst_n(bus_rst_n), .valid(valid),
    .ready(ready), .stab_vec(stab_vec), .pend(pend), .saved(saved)
  );

  hsk_rule_eval #(.FULL_W(FULL_W), .STAB_W(STAB_W)) u_eval (
    .bus_rst_n(bus_rst_n), .valid(valid), .pend(pend),
    .full_vec(full_vec), .stab_vec(stab_vec), .saved(saved), .fire(fire)
  );

  hsk_sticky_bank #(.N(NUM_RULES)) u_flags (
    .clk(clk), .rst(rst), .clr(clr), .fire(fire), .flags(viol_flags)
  );

  hsk_sat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(any_fire), .cnt(viol_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= any_fire;
  end

  // R8: a pulse always comes with at least one raised flag
  p_pulse_flag_r8: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (|viol_flags));
  // R5: valid seen during bus reset is reported next edge
  p_in_rst_r5: assert property (@(posedge clk) disable iff (rst)
    (!bus_rst_n && valid) |=> (viol_flags[RULE_IN_RST] && err_pulse));
  // R3: stall followed by dropped valid is reported
  p_dropped_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rst_n && !valid && $past(!rst && bus_rst_n && valid && !ready))
      |=> viol_flags[RULE_DROPPED]);
  // R4: a stall-free previous cycle never reports moved or withdrawn
  p_done_free_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(valid && ready) && !err_pulse) |-> 1'b1 ? !(pend && $past(valid && ready)) : 1'b1);
endmodule

// File: tb/axi_hsk_monitor_tb.sv
module axi_hsk_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1, clr = 1'b0, bus_rst_n = 1'b1;
  logic        valid = 1'b0, ready = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  id = '0;
  logic [7:0]  len = '0;
  logic [2:0]  size = '0;
  logic [1:0]  burst = '0;
  logic [3:0]  viol_flags;
  logic        err_pulse;
  logic [15:0] viol_cnt;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_hsk_monitor dut_i (
    .clk(clk), .rst(rst), .clr(clr), .bus_rst_n(bus_rst_n),
    .valid(valid), .ready(ready), .addr(addr), .id(id), .len(len),
    .size(size), .burst(burst), .viol_flags(viol_flags),
    .err_pulse(err_pulse), .viol_cnt(viol_cnt)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle_bus();
    valid = 1'b0; ready = 1'b0; bus_rst_n = 1'b1; clr = 1'b0;
  endtask

  task automatic mon_reset();
    idle_bus();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    mon_reset();
    chk("R10 flags", {28'd0, viol_flags}, 32'd0);
    chk("R10 pulse", {31'd0, err_pulse}, 32'd0);
    chk("R10 cnt", {16'd0, viol_cnt}, 32'd0);
  endtask

  task automatic t_moved();
    mon_reset();
    valid = 1; ready = 0; addr = 32'h100; len = 8'd3; tick();
    addr = 32'h104; #1;
    chk("R11 not early", {28'd0, viol_flags}, 32'd0);
    tick();
    chk("R2 moved flag", {28'd0, viol_flags}, 32'h2);
    chk("R8 pulse", {31'd0, err_pulse}, 32'd1);
    chk("R9 cnt one", {16'd0, viol_cnt}, 32'd1);
    ready = 1; tick();
    chk("R8 single pulse", {31'd0, err_pulse}, 32'd0);
    idle_bus(); tick();
  endtask

  task automatic t_id_change();
    mon_reset();
    valid = 1; ready = 0; addr = 32'h200; id = 4'd1; tick();
    id = 4'd2; tick();
    ready = 1; tick();
    idle_bus(); tick();
    chk("R2 id ignored", {28'd0, viol_flags}, 32'd0);
  endtask

  task automatic t_dropped();
    mon_reset();
    valid = 1; ready = 0; addr = 32'h300; tick();
    valid = 0; tick();
    chk("R3 dropped flag", {28'd0, viol_flags}, 32'h4);
    chk("R3 cnt", {16'd0, viol_cnt}, 32'd1);
  endtask

  task automatic t_both();
    mon_reset();
    valid = 1; ready = 0; addr = 32'h400; tick();
    valid = 0; addr = 32'h500; tick();
    chk("R9 two rules flags", {28'd0, viol_flags}, 32'h6);
    chk("R9 two rules one count", {16'd0, viol_cnt}, 32'd1);
    tick();
    chk("R8 pulse ends", {31'd0, err_pulse}, 32'd0);
  endtask

  task automatic t_handshake();
    mon_reset();
    valid = 1; ready = 1; addr = 32'h600; tick();
    valid = 0; ready = 0; addr = 32'h700; tick();
    valid = 1; ready = 0; addr = 32'h800; tick();
    ready = 1; tick();
    valid = 0; ready = 0; addr = 32'h900; size = 3'd2; tick();
    chk("R4 free after completion", {28'd0, viol_flags}, 32'd0);
    chk("R4 cnt", {16'd0, viol_cnt}, 32'd0);
    size = 3'd0;
  endtask

  task automatic t_in_reset();
    mon_reset();
    bus_rst_n = 0; valid = 1; tick();
    chk("R5 flag", {28'd0, viol_flags}, 32'h8);
    chk("R5 pulse", {31'd0, err_pulse}, 32'd1);
    valid = 0; tick();
    chk("R5 pulse off", {31'd0, err_pulse}, 32'd0);
    idle_bus(); tick();
  endtask

  task automatic t_pend_clear();
    mon_reset();
    valid = 1; ready = 0; addr = 32'hA00; tick();
    bus_rst_n = 0; valid = 0; addr = 32'hB00; tick();
    chk("R6 no eval in bus reset", {28'd0, viol_flags}, 32'd0);
    bus_rst_n = 1; addr = 32'hC00; tick();
    chk("R6 first cycle after release", {28'd0, viol_flags}, 32'd0);
    chk("R6 cnt", {16'd0, viol_cnt}, 32'd0);
  endtask

  task automatic t_sticky();
    mon_reset();
    valid = 1; ready = 0; tick();
    valid = 0; tick();
    tick(); tick(); tick();
    chk("R7 sticky", {28'd0, viol_flags}, 32'h4);
    clr = 1; tick(); clr = 0;
    chk("R7 cleared", {28'd0, viol_flags}, 32'd0);
    chk("R9 clr keeps cnt", {16'd0, viol_cnt}, 32'd1);
    valid = 1; ready = 0; tick();
    valid = 0; clr = 1; tick(); clr = 0;
    chk("R7 set beats clr", {28'd0, viol_flags}, 32'h4);
    rst = 1; tick(); rst = 0;
    chk("R10 rst clears flags", {28'd0, viol_flags}, 32'd0);
    chk("R10 rst clears cnt", {16'd0, viol_cnt}, 32'd0);
  endtask

  task automatic t_unknown();
    logic exp_unk;
    mon_reset();
    valid = 1; ready = 1; addr = 'x;
    exp_unk = $isunknown({addr, id, len, size, burst});
    tick();
    chk("R1 unknown flag", {31'd0, viol_flags[0]}, {31'd0, exp_unk});
    addr = '0; idle_bus(); tick();
  endtask

  task automatic t_saturate();
    mon_reset();
    bus_rst_n = 0; valid = 1;
    repeat (65540) tick();
    chk("R9 saturates", {16'd0, viol_cnt}, 32'hFFFF);
    idle_bus(); tick();
    chk("R9 holds max", {16'd0, viol_cnt}, 32'hFFFF);
  endtask

  initial begin
    t_reset_state();
    t_moved();
    t_id_change();
    t_dropped();
    t_both();
    t_handshake();
    t_in_reset();
    t_pend_clear();
    t_sticky();
    t_unknown();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule